// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state before normal traffic begins. A pulse on `start` captures a 32-bit timing configuration and a bus-width flag. From them the block derives the mode-register value. It then writes a sequence of control words on `ctrlWord`, with a one-cycle `ctrlWe` strobe for each write. First comes an enable word with automatic refresh turned off. Then comes a long settle wait. Then comes a fixed list of commands, with idle cycles between them. Last, the block writes back the configured word with refresh restored.

The whole pass runs a parameterised number of times, two by default, because some devices need a second initialization to come up reliably. When the final pass has finished, `done` rises and stays high. The last control word is held until a new `start` or a reset arrives. The settle wait is counted in clock cycles, derived from the clock frequency and the wait length in microseconds.

Top module: `sdram_init_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `ctrlWord` to zero, which puts the command field in bits 10:9 at the NOP code 0. It also drops `ctrlWe` and `done` and returns the block to idle.
- R2: `start`, sampled in idle or done, latches `cfgTiming` and `cfgWide`. The first write of each pass is the enable word: (cfg AND 0x8000F9FF) OR 0x8000C000 OR (mode << 16). Changes to the inputs after the latch have no effect.
- R3: When cfg bits 23:16 are zero, the mode value is computed. cfg bit 12 = 1 selects 100 MHz, where CAS code (cfg bits 1:0) 0 means CAS 2. cfg bit 12 = 0 selects 50 MHz, where code 1 means CAS 2. Every other code means CAS 3. CAS 2 gives 0x40 and CAS 3 gives 0x60 when `cfgWide` = 1 (32-bit bus). Both values are halved when `cfgWide` = 0 (16-bit bus).
- R4: A nonzero value in cfg bits 23:16 is used unchanged as the mode value, whatever the speed, CAS code and width.
- R5: After the enable word, exactly WAIT_CYCLES = CLK_MHZ*WAIT_US idle cycles pass (with `ctrlWe` low) before the first command is written.
- R6: The command list has 2*(REFRESHES+2) entries, 20 by default. It runs: precharge (code 3), NOP (0), REFRESHES pairs of auto-refresh (2) and NOP, then mode-register set (1) and NOP. Each entry is the enable word with the code placed at bits 10:9. Bits 15:14 read 11 on every non-NOP command.
- R7: Consecutive command writes, and the last command and the restore word, are separated by exactly GAP_CYCLES idle cycles (at least 5).
- R8: After the last command entry, the restore word (cfg AND 0x8000F9FF) OR 0x80000000 is written. This word has refresh as configured, the command field zeroed and the mode field cleared.
- R9: The pass of R2 through R8 repeats PASSES times. Each later enable word follows the previous restore word with no idle cycle between them.
- R10: `done` rises in the same cycle as the final restore word and stays high, with `ctrlWord` unchanged, until `start` or reset. `done` is low during a sequence.
- R11: `ctrlWe` is high for exactly one cycle per write. `ctrlWord` is stable in every cycle that has no write.
- R12: A reset in the middle of a sequence aborts it: `ctrlWord` becomes 0 and no further write occurs without a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the sequence and latches the configuration |
| cfgTiming | input | 32 | Timing configuration: speed bit 12, CAS code 1:0, optional mode value 23:16 |
| cfgWide | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| ctrlWord | output | 32 | Timing/command control word |
| ctrlWe | output | 1 | One-cycle strobe marking each control word write |
| done | output | 1 | All passes complete |

## Verification
On every cycle, the assertions check several properties. The minimum idle spacing before each command is checked through a cycle counter, along with the settle wait before the first command. They also check that every written word carries the enable bit and that real commands are issued with automatic refresh off. Finally, they check that the control word holds between writes and that `done` stays up until a new start. Only the bench scenarios show the rest. This covers the exact order and codes of the command list and the mode value for each combination of speed, CAS code, width and override. It also covers the restore word, the pass repetition, and an abort by reset partway through the wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_MRS = 2'd1,
    CMD_REF = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       latch;
    logic       wrInit;
    logic       wrCmd;
    logic       wrRestore;
    logic [1:0] cmdCode;
  } seqStrobe_t;

  localparam logic [31:0] KEEP_MASK  = 32'h8000_F9FF;
  localparam logic [31:0] ENABLE_BIT = 32'h8000_0000;
  localparam logic [31:0] REF_OFF    = 32'h0000_C000;
  localparam int          CMD_LSB    = 9;
  localparam int          MODE_LSB   = 16;

  // Entry of the fixed command list: even slots carry commands, odd slots NOP
  function automatic cmd_e cmdAt(input int idx, input int refreshes);
    if (idx % 2 == 1)           return CMD_NOP;
    else if (idx == 0)          return CMD_PRE;
    else if (idx / 2 <= refreshes) return CMD_REF;
    else                        return CMD_MRS;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYCLES = 50000,
  parameter int GAP_CYCLES  = 5,
  parameter int PASSES      = 2,
  parameter int REFRESHES   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output seqStrobe_t strb,
  output logic       done
);

  localparam int NUM_CMDS = 2 * (REFRESHES + 2);
  localparam int IDXW     = $clog2(NUM_CMDS);
  localparam int CNTMAX   = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
  localparam int CNTW     = $clog2(CNTMAX + 1);
  localparam int PASSW    = (PASSES > 1) ? $clog2(PASSES) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_WAIT, S_CMD, S_GAP, S_RESTORE, S_DONE
  } state_e;

  state_e            state;
  logic [CNTW-1:0]   cnt;
  logic [IDXW-1:0]   idx;
  logic [PASSW-1:0]  pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      pass  <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            state <= S_INIT;
            pass  <= '0;
          end
        end
        S_INIT: begin
          state <= S_WAIT;
          cnt   <= '0;
          idx   <= '0;
        end
        S_WAIT: begin
          if (cnt == CNTW'(WAIT_CYCLES - 1)) state <= S_CMD;
          else cnt <= cnt + 1'b1;
        end
        S_CMD: begin
          state <= S_GAP;
          cnt   <= '0;
        end
        S_GAP: begin
          if (cnt == CNTW'(GAP_CYCLES - 1)) begin
            if (idx == IDXW'(NUM_CMDS - 1)) state <= S_RESTORE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_CMD;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RESTORE: begin
          if (pass == PASSW'(PASSES - 1)) state <= S_DONE;
          else begin
            pass  <= pass + 1'b1;
            state <= S_INIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latch     = start && (state == S_IDLE || state == S_DONE);
    strb.wrInit    = (state == S_INIT);
    strb.wrCmd     = (state == S_CMD);
    strb.wrRestore = (state == S_RESTORE);
    strb.cmdCode   = cmdAt(int'(idx), REFRESHES);
  end

  assign done = (state == S_DONE);

  // Checker counter: cycles since the last write strobe, saturating
  logic [CNTW-1:0] sinceWr;
  always_ff @(posedge clk) begin
    if (rst) sinceWr <= '0;
    else if (strb.wrInit || strb.wrCmd || strb.wrRestore) sinceWr <= '0;
    else if (sinceWr != CNTW'(CNTMAX)) sinceWr <= sinceWr + 1'b1;
  end

  // R5
  settle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCmd && idx == '0) |-> sinceWr >= CNTW'(WAIT_CYCLES));

  // R7
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ((strb.wrCmd && idx != '0) || strb.wrRestore) |-> sinceWr >= CNTW'(GAP_CYCLES));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seqStrobe_t  strb,
  input  logic [31:0] cfgTiming,
  input  logic        cfgWide,
  output logic [31:0] ctrlWord,
  output logic        ctrlWe
);

  logic [31:0] cfgQ;
  logic        wideQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ  <= '0;
      wideQ <= 1'b0;
    end else if (strb.latch) begin
      cfgQ  <= cfgTiming;
      wideQ <= cfgWide;
    end
  end

  logic       cas3;
  logic [7:0] calcMode;
  logic [7:0] modeData;

  always_comb begin
    // 100 MHz: code 0 is CAS 2; 50 MHz: code 1 is CAS 2
    if (cfgQ[12]) cas3 = (cfgQ[1:0] != 2'd0);
    else          cas3 = (cfgQ[1:0] != 2'd1);
    calcMode = cas3 ? 8'h60 : 8'h40;
    if (cfgQ[23:16] != 8'h00) modeData = cfgQ[23:16];
    else if (wideQ)           modeData = calcMode;
    else                      modeData = calcMode >> 1;
  end

  logic [31:0] baseWord;
  logic [31:0] initWord;
  logic [31:0] cmdWord;

  assign baseWord = (cfgQ & KEEP_MASK) | ENABLE_BIT;
  assign initWord = baseWord | REF_OFF | (32'(modeData) << MODE_LSB);
  assign cmdWord  = initWord | (32'(strb.cmdCode) << CMD_LSB);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlWord <= '0;
      ctrlWe   <= 1'b0;
    end else begin
      ctrlWe <= strb.wrInit | strb.wrCmd | strb.wrRestore;
      if (strb.wrInit)         ctrlWord <= initWord;
      else if (strb.wrCmd)     ctrlWord <= cmdWord;
      else if (strb.wrRestore) ctrlWord <= baseWord;
    end
  end

  // R2
  enable_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlWe |-> ctrlWord[31]);

  // R6
  cmd_refresh_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlWe && ctrlWord[10:9] != 2'd0) |-> ctrlWord[15:14] == 2'b11);

  // R11
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrInit || strb.wrCmd || strb.wrRestore) |=> $stable(ctrlWord) && !ctrlWe);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int WAIT_US    = 200,
  parameter int GAP_CYCLES = 5,
  parameter int PASSES     = 2,
  parameter int REFRESHES  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] cfgTiming,
  input  logic        cfgWide,
  output logic [31:0] ctrlWord,
  output logic        ctrlWe,
  output logic        done
);

  localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;

  seqStrobe_t strb;

  sdram_init_ctrl #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES),
    .PASSES      (PASSES),
    .REFRESHES   (REFRESHES)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  sdram_init_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgTiming (cfgTiming),
    .cfgWide   (cfgWide),
    .ctrlWord  (ctrlWord),
    .ctrlWe    (ctrlWe)
  );

endmodule

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam int CLK_MHZ = 1;
  localparam int WAIT_US = 40;
  localparam int W       = CLK_MHZ * WAIT_US;
  localparam int GAP     = 5;
  localparam int PASSES  = 2;
  localparam int REFS    = 8;
  localparam int NCMD    = 2 * (REFS + 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfgTiming = '0;
  logic        cfgWide = 1'b0;
  logic [31:0] ctrlWord;
  logic        ctrlWe;
  logic        done;

  always #2 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .GAP_CYCLES(GAP),
    .PASSES(PASSES), .REFRESHES(REFS)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .cfgTiming(cfgTiming),
    .cfgWide(cfgWide), .ctrlWord(ctrlWord), .ctrlWe(ctrlWe), .done(done)
  );

  typedef struct {
    logic [31:0] word;
    int          idle;
    logic        last;
    string       tag;
  } item_t;

  item_t q[$];
  item_t it;
  int checks = 0;
  int fails  = 0;
  int idleCnt = 0;
  bit finished = 0;

  function automatic logic [7:0] expMode(input logic [31:0] c, input logic wide);
    logic cas2;
    logic [7:0] v;
    if (c[23:16] != 8'h00) return c[23:16];
    cas2 = c[12] ? (c[1:0] == 2'd0) : (c[1:0] == 2'd1);
    v = cas2 ? 8'h40 : 8'h60;
    if (!wide) v = v >> 1;
    return v;
  endfunction

  function automatic logic [1:0] expCode(input int i);
    if (i % 2 == 1) return 2'd0;
    if (i == 0) return 2'd3;
    if (i == NCMD - 2) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst) idleCnt = 0;
    else if (ctrlWe) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected write actual %h expected none", ctrlWord);
      end else begin
        it = q.pop_front();
        if (ctrlWord !== it.word || done !== it.last ||
            (it.idle >= 0 && idleCnt != it.idle)) begin
          fails++;
          $display("FAIL %s word actual %h expected %h, done actual %b expected %b, idle actual %0d expected %0d",
                   it.tag, ctrlWord, it.word, done, it.last, idleCnt, it.idle);
        end
      end
      idleCnt = 0;
    end else idleCnt++;
  end

  // Driver: pushes expected writes, launches one sequence
  task automatic runSeq(input logic [31:0] cfg, input logic wide, input string modeTag);
    logic [31:0] base, init;
    item_t e;
    base = (cfg & 32'h8000F9FF) | 32'h80000000;
    init = base | 32'h0000C000 | (32'(expMode(cfg, wide)) << 16);
    for (int p = 0; p < PASSES; p++) begin
      e.word = init; e.idle = (p == 0) ? -1 : 0; e.last = 1'b0;
      e.tag = (p == 0) ? {"R2 ", modeTag} : {"R9 ", modeTag};
      q.push_back(e);
      for (int i = 0; i < NCMD; i++) begin
        e.word = init | (32'(expCode(i)) << 9);
        e.idle = (i == 0) ? W : GAP;
        e.last = 1'b0;
        e.tag  = (i == 0) ? "R5 R6" : ((i == NCMD - 2) ? {"R6 R7 ", modeTag} : "R6 R7");
        q.push_back(e);
      end
      e.word = base; e.idle = GAP; e.last = (p == PASSES - 1); e.tag = "R8 R10";
      q.push_back(e);
    end
    cfgTiming = cfg;
    cfgWide   = wide;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cfgTiming = ~cfg;      // R2: must be ignored after latch
    cfgWide   = ~wide;
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
    check(done === 1'b1 && ctrlWord === base, "R10 done with restore word", ctrlWord, base);
    repeat (4) @(negedge clk);
    check(done === 1'b1 && ctrlWord === base && ctrlWe === 1'b0, "R10 R11 hold after done", ctrlWord, base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ctrlWord === 32'h0 && ctrlWe === 1'b0 && done === 1'b0, "R1 reset state", ctrlWord, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(ctrlWord === 32'h0 && done === 1'b0, "R1 idle after reset", ctrlWord, 32'h0);

    runSeq(32'h4500_3E01, 1'b1, "R3"); // 100 MHz, code 1 -> CAS3 -> 0x60 wide
    runSeq(32'h0000_1000, 1'b1, "R3"); // 100 MHz, code 0 -> CAS2 -> 0x40
    runSeq(32'h7F00_D002, 1'b0, "R3"); // 100 MHz, code 2 -> CAS3 narrow -> 0x30
    runSeq(32'h0000_0201, 1'b1, "R3"); // 50 MHz, code 1 -> CAS2 -> 0x40
    runSeq(32'h8000_4000, 1'b0, "R3"); // 50 MHz, code 0 -> CAS3 narrow -> 0x30
    runSeq(32'h005A_1003, 1'b0, "R4"); // override 0x5A

    // R12: abort mid-wait
    cfgTiming = 32'h0000_1000; cfgWide = 1'b1;
    for (int i = 0; i < 2 + 2 * (NCMD + 2); i++) begin
      item_t e;
      e.word = 32'h0; e.idle = -1; e.last = 1'b0; e.tag = "R12";
      q.push_back(e);
    end
    q.delete();
    begin
      item_t e;
      e.word = (32'h0000_1000 & 32'h8000F9FF) | 32'h8000C000 | (32'h40 << 16);
      e.idle = -1; e.last = 1'b0; e.tag = "R12 R2";
      q.push_back(e);
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (W / 2) @(negedge clk);
    check(q.size() == 0, "R12 enable word before abort", 32'(q.size()), 32'h0);
    rst = 1'b1;
    @(posedge clk);
    #1 q.delete();
    @(negedge clk);
    check(ctrlWord === 32'h0 && done === 1'b0 && ctrlWe === 1'b0, "R12 R1 abort clears word", ctrlWord, 32'h0);
    rst = 1'b0;
    repeat (W + 20) @(negedge clk);
    check(ctrlWord === 32'h0 && done === 1'b0, "R12 no writes after abort", ctrlWord, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule